// File: doc/BRIEF.md
# Multi-Mode Timer with Compare-Driven Waveform Output

This block is a counter with a single compare channel. Once it is configured, it produces a periodic waveform on one output pin with no software involvement. Registers outside the block supply the compare value, the counting mode, the output mode and the tick source select. The block returns a compare flag, a zero flag and the waveform pin. All logic runs on one system clock. The timer advances only in cycles where the selected tick enable (slow or fast) is high.

Four counting modes are offered. Halt freezes the count where it is. Up counts from 0 to the compare value and then wraps. Free-running counts through the full range. Up/down climbs to the compare value and then descends to zero. Each mode fires the flags at different steps, so with compare value N the toggle waveform has a different frequency in each mode:

- In up mode the output frequency is the tick rate divided by 2(N+1).
- In up/down mode it is the tick rate divided by 4N.

No data stream passes through the block, so there is no valid/ready interface. Every input is a plain level or a one-cycle strobe, sampled at the rising clock edge.

Top module: `cmp_toggle_timer`

## Requirements
- R1: In up mode (mode code 1) with compare value N, each selected tick advances the count by one until it equals N. The tick after that returns it to 0, giving a period of N+1 ticks.
- R2: In free-running mode (mode code 2), the count wraps from all-ones to 0. The zero flag is set by that wrap.
- R3: In up/down mode (mode code 3) with compare value N ≥ 1, the count runs 0,1,…,N and then N-1,…,0, a period of 2N ticks. The direction output is 1 from the step that reaches N until the step that reaches 0.
- R4: The compare flag is set by a step whose new count equals the compare value. In up/down mode this holds only for an upward step from N-1 to N.
- R5: The zero flag is set when up mode wraps to 0. In up/down mode it is set when the count steps down from 1 to 0.
- R6: In toggle output mode (output code 1), the waveform output inverts on every step that sets the compare flag.
- R7: Output code 2 sets the waveform to 1 on a compare step. Output code 3 clears it to 0 on a compare step. Output code 0 copies the force-level input into the waveform register each cycle.
- R8: When the source select is 0 the timer steps only on the slow tick. When it is 1 the timer steps only on the fast tick. With no selected tick, the count and direction hold.
- R9: Halt mode (mode code 0) freezes the count and direction without resetting them.
- R10: Reset and the synchronous clear input both force the count to 0, the direction to up and the waveform to 0. Clear takes priority over a tick in the same cycle.
- R11: The flags are sticky. Flag-clear bit 0 clears the compare flag and bit 1 clears the zero flag. A set in the same cycle as a clear wins.
- R12: A compare value written while halted is used by the first step after counting resumes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_slow | input | 1 | Slow tick enable |
| tick_fast | input | 1 | Fast tick enable |
| src_sel | input | 1 | Tick source select: 0 slow, 1 fast |
| mode_i | input | 2 | Counting mode: 0 halt, 1 up, 2 free-running, 3 up/down |
| out_mode_i | input | 2 | Output mode: 0 force, 1 toggle, 2 set, 3 clear |
| force_lvl_i | input | 1 | Level copied to the waveform in output mode 0 |
| cmp_wr_i | input | 1 | Compare value write strobe |
| cmp_wdata_i | input | CNT_W | Compare value to write |
| sync_clr_i | input | 1 | Synchronous clear of count, direction and waveform |
| flag_clr_i | input | 2 | Write-one-to-clear: bit 0 compare flag, bit 1 zero flag |
| count_o | output | CNT_W | Current count |
| dir_down_o | output | 1 | 1 while counting down in up/down mode |
| cmp_flag_o | output | 1 | Sticky compare flag |
| zero_flag_o | output | 1 | Sticky zero/overflow flag |
| wave_o | output | 1 | Waveform output |

## Verification
Some rules can be judged from one cycle to the next, and the assertions check these on every cycle:

- a single up-mode increment;
- the wrap at the compare value;
- the down step from 1 to 0 in up/down mode;
- the hold in halt or without a selected tick;
- the effect of a clear;
- a toggle on a compare step;
- the forced level.

Other behaviour builds up over many steps, so only the bench scenarios can show it. This covers the full period and waveform parity in each mode for a sweep of compare values, the absence of a compare flag on the downward half, a compare value written while halted, and a flag set racing its clear.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    CM_HALT = 2'd0,
    CM_UP   = 2'd1,
    CM_FREE = 2'd2,
    CM_UPDN = 2'd3
  } cnt_mode_e;

  typedef enum logic [1:0] {
    OM_FORCE  = 2'd0,
    OM_TOGGLE = 2'd1,
    OM_SET    = 2'd2,
    OM_RESET  = 2'd3
  } out_mode_e;

  localparam int unsigned N_FLAGS = 2;
  localparam int unsigned FLG_CMP = 0;
  localparam int unsigned FLG_ZERO = 1;
endpackage

// File: rtl/tick_select.sv
module tick_select #(
  parameter int unsigned N_SRC = 2,
  localparam int unsigned SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] ticks,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  always_comb begin
    tick = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (sel == SEL_W'(i)) tick = ticks[i];
    end
  end
endmodule

// File: rtl/count_engine.sv
module count_engine
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  cnt_mode_e        mode,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] cnt,
  output logic             dn,
  output logic             ev_cmp,
  output logic             ev_zero
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] nxt;
  logic             nxt_dn, hit_c, hit_z;

  always_comb begin
    nxt    = cnt;
    nxt_dn = dn;
    hit_c  = 1'b0;
    hit_z  = 1'b0;
    unique case (mode)
      CM_HALT: ;
      CM_UP: begin
        nxt_dn = 1'b0;
        if (cnt >= cmp) begin
          nxt   = ZERO;
          hit_z = 1'b1;
        end else begin
          nxt = cnt + ONE;
        end
        hit_c = (nxt == cmp);
      end
      CM_FREE: begin
        nxt_dn = 1'b0;
        nxt    = cnt + ONE;
        hit_z  = (cnt == MAXV);
        hit_c  = (nxt == cmp);
      end
      CM_UPDN: begin
        if ((dn || cnt > cmp) && cnt != ZERO) begin
          nxt    = cnt - ONE;
          nxt_dn = 1'b1;
          if (nxt == ZERO) begin
            nxt_dn = 1'b0;
            hit_z  = 1'b1;
          end
        end else if (cnt < cmp) begin
          nxt    = cnt + ONE;
          nxt_dn = 1'b0;
          if (nxt == cmp) begin
            hit_c  = 1'b1;
            nxt_dn = 1'b1;
          end
        end else begin
          nxt_dn = 1'b0;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= ZERO;
      dn  <= 1'b0;
    end else if (clr) begin
      cnt <= ZERO;
      dn  <= 1'b0;
    end else if (tick) begin
      cnt <= nxt;
      dn  <= nxt_dn;
    end
  end

  assign ev_cmp  = tick && !clr && hit_c;
  assign ev_zero = tick && !clr && hit_z;
endmodule

// File: rtl/wave_out.sv
module wave_out
  import tmr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  logic      ev_cmp,
  input  out_mode_e omode,
  input  logic      force_lvl,
  output logic      wave
);
  logic nxt;

  always_comb begin
    nxt = wave;
    unique case (omode)
      OM_FORCE:  nxt = force_lvl;
      OM_TOGGLE: if (ev_cmp) nxt = ~wave;
      OM_SET:    if (ev_cmp) nxt = 1'b1;
      OM_RESET:  if (ev_cmp) nxt = 1'b0;
      default:   ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   wave <= 1'b0;
    else if (clr) wave <= 1'b0;
    else          wave <= nxt;
  end
endmodule

// File: rtl/flag_regs.sv
module flag_regs #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flags[i] <= 1'b0;
      else if (set[i]) flags[i] <= 1'b1;
      else if (clr[i]) flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/cmp_toggle_timer.sv
module cmp_toggle_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_slow,
  input  logic             tick_fast,
  input  logic             src_sel,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       out_mode_i,
  input  logic             force_lvl_i,
  input  logic             cmp_wr_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  input  logic             sync_clr_i,
  input  logic [1:0]       flag_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_down_o,
  output logic             cmp_flag_o,
  output logic             zero_flag_o,
  output logic             wave_o
);
  logic [CNT_W-1:0]   cmp_q;
  logic               tick;
  logic               ev_cmp, ev_zero;
  logic [N_FLAGS-1:0] flag_set, flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cmp_q <= '0;
    else if (cmp_wr_i) cmp_q <= cmp_wdata_i;
  end

  tick_select #(.N_SRC(2)) u_sel (
    .ticks ({tick_fast, tick_slow}),
    .sel   (src_sel),
    .tick  (tick)
  );

  count_engine #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (sync_clr_i),
    .tick    (tick),
    .mode    (cnt_mode_e'(mode_i)),
    .cmp     (cmp_q),
    .cnt     (count_o),
    .dn      (dir_down_o),
    .ev_cmp  (ev_cmp),
    .ev_zero (ev_zero)
  );

  wave_out u_wave (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (sync_clr_i),
    .ev_cmp    (ev_cmp),
    .omode     (out_mode_e'(out_mode_i)),
    .force_lvl (force_lvl_i),
    .wave      (wave_o)
  );

  always_comb begin
    flag_set           = '0;
    flag_set[FLG_CMP]  = ev_cmp;
    flag_set[FLG_ZERO] = ev_zero;
  end

  flag_regs #(.N(N_FLAGS)) u_flg (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (flag_set),
    .clr   (flag_clr_i),
    .flags (flags)
  );

  assign cmp_flag_o  = flags[FLG_CMP];
  assign zero_flag_o = flags[FLG_ZERO];
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_slow,
  input logic             tick_fast,
  input logic             src_sel,
  input logic [1:0]       mode_i,
  input logic [1:0]       out_mode_i,
  input logic             force_lvl_i,
  input logic             sync_clr_i,
  input logic [1:0]       flag_clr_i,
  input logic [CNT_W-1:0] cmp_q,
  input logic [CNT_W-1:0] count_o,
  input logic             dir_down_o,
  input logic             cmp_flag_o,
  input logic             zero_flag_o,
  input logic             wave_o
);
  logic tk;
  assign tk = src_sel ? tick_fast : tick_slow;

  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd1 && tk && !sync_clr_i && count_o < cmp_q) |=> count_o == CNT_W'($past(count_o) + 1'b1)); // R1
  AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd1 && tk && !sync_clr_i && count_o >= cmp_q) |=> (count_o == '0 && zero_flag_o)); // R5
  AST_UPDN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd3 && tk && !sync_clr_i && dir_down_o && count_o == CNT_W'(1)) |=> (count_o == '0 && !dir_down_o && zero_flag_o)); // R3
  AST_TOGGLE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode_i == 2'd1 && mode_i == 2'd1 && tk && !sync_clr_i && count_o < cmp_q && CNT_W'(count_o + 1'b1) == cmp_q) |=> wave_o != $past(wave_o)); // R6
  AST_FORCE_LVL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode_i == 2'd0 && !sync_clr_i) |=> wave_o == $past(force_lvl_i)); // R7
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tk && !sync_clr_i) |=> ($stable(count_o) && $stable(dir_down_o))); // R8
  AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd0 && !sync_clr_i) |=> ($stable(count_o) && $stable(dir_down_o))); // R9
  AST_CLEAR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_clr_i |=> (count_o == '0 && !dir_down_o && !wave_o)); // R10
  AST_FLAG_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr_i[0] && (!tk || mode_i == 2'd0 || sync_clr_i)) |=> !cmp_flag_o); // R11
endmodule

bind cmp_toggle_timer tmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_slow(tick_slow), .tick_fast(tick_fast),
  .src_sel(src_sel), .mode_i(mode_i), .out_mode_i(out_mode_i),
  .force_lvl_i(force_lvl_i), .sync_clr_i(sync_clr_i), .flag_clr_i(flag_clr_i),
  .cmp_q(cmp_q), .count_o(count_o), .dir_down_o(dir_down_o),
  .cmp_flag_o(cmp_flag_o), .zero_flag_o(zero_flag_o), .wave_o(wave_o)
);

// File: tb/sim_cmp_toggle_timer.sv
`timescale 1ns/1ps
module sim_cmp_toggle_timer;
  localparam int W = 4;
  logic clk = 0, rst_n = 0;
  logic tick_slow = 0, tick_fast = 0, src_sel = 1;
  logic [1:0] mode_i = 0, out_mode_i = 1, flag_clr_i = 0;
  logic force_lvl_i = 0, cmp_wr_i = 0, sync_clr_i = 0;
  logic [W-1:0] cmp_wdata_i = 0, count_o;
  logic dir_down_o, cmp_flag_o, zero_flag_o, wave_o;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cmp_toggle_timer #(.CNT_W(W)) u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk) tick_fast = 1;
    @(negedge clk) tick_fast = 0;
  endtask

  task automatic clr_flags();
    @(negedge clk) flag_clr_i = 2'b11;
    @(negedge clk) flag_clr_i = 2'b00;
  endtask

  task automatic setup(input int md, input int om, input int n);
    @(negedge clk);
    mode_i = 0; sync_clr_i = 1; cmp_wr_i = 1; cmp_wdata_i = W'(n); flag_clr_i = 2'b11;
    @(negedge clk);
    sync_clr_i = 0; cmp_wr_i = 0; flag_clr_i = 0; mode_i = 2'(md); out_mode_i = 2'(om);
  endtask

  initial begin
    #(20 * 200000);
    nfail++;
    $display("FAIL watchdog: actual 0 expected 1 (completion)");
    if (!done) begin
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(count_o == 0 && !dir_down_o && !wave_o, "R10 reset state", count_o, 0);
    chk(!cmp_flag_o && !zero_flag_o, "R11 reset flags", {cmp_flag_o, zero_flag_o}, 0);
    rst_n = 1;

    // R1 R4 R5 R6 up-mode sweep
    for (int n = 1; n <= 6; n++) begin
      int kmax;
      setup(1, 1, n);
      kmax = 3 * (n + 1);
      for (int k = 1; k <= kmax; k++) begin
        step();
        chk(count_o == W'(k % (n + 1)), "R1 up count", count_o, k % (n + 1));
        if (k == n - 1) chk(!cmp_flag_o, "R4 up cmp flag early", cmp_flag_o, 0);
        if (k == n) begin
          chk(cmp_flag_o, "R4 up cmp flag", cmp_flag_o, 1);
          chk(!zero_flag_o, "R5 up zero flag early", zero_flag_o, 0);
        end
        if (k == n + 1) chk(zero_flag_o, "R5 up zero flag", zero_flag_o, 1);
      end
      chk(wave_o == 1'(((kmax + 1) / (n + 1)) & 1), "R6 up toggle parity", wave_o, ((kmax + 1) / (n + 1)) & 1);
    end

    // R3 R4 R5 R6 up/down sweep
    for (int n = 1; n <= 6; n++) begin
      int kmax, p, ec;
      setup(3, 1, n);
      kmax = 5 * n;
      for (int k = 1; k <= kmax; k++) begin
        step();
        p = k % (2 * n);
        chk(count_o == W'((p <= n) ? p : 2 * n - p), "R3 updown count", count_o, (p <= n) ? p : 2 * n - p);
        chk(dir_down_o == (p >= n), "R3 updown direction", dir_down_o, p >= n);
        if (k == n) begin
          chk(cmp_flag_o, "R4 updown cmp flag", cmp_flag_o, 1);
          chk(!zero_flag_o, "R5 updown zero early", zero_flag_o, 0);
          clr_flags();
        end
        if (k == 2 * n) begin
          chk(!cmp_flag_o, "R4 no cmp flag on descent", cmp_flag_o, 0);
          chk(zero_flag_o, "R5 updown zero flag", zero_flag_o, 1);
        end
      end
      ec = (kmax + n) / (2 * n);
      chk(wave_o == 1'(ec & 1), "R6 updown toggle parity", wave_o, ec & 1);
    end

    // R2 free-running
    setup(2, 1, 5);
    for (int k = 1; k <= 40; k++) begin
      step();
      chk(count_o == W'(k % 16), "R2 free count", count_o, k % 16);
      if (k == 15) chk(!zero_flag_o, "R2 zero before wrap", zero_flag_o, 0);
      if (k == 16) chk(zero_flag_o, "R2 zero on wrap", zero_flag_o, 1);
    end
    chk(wave_o == 1'(((40 + 11) / 16) & 1), "R6 free toggle parity", wave_o, ((40 + 11) / 16) & 1);

    // R8 tick source select
    setup(1, 1, 6);
    src_sel = 0;
    step();
    chk(count_o == 0, "R8 unselected fast tick ignored", count_o, 0);
    @(negedge clk) tick_slow = 1;
    @(negedge clk) tick_slow = 0;
    chk(count_o == 1, "R8 slow tick counted", count_o, 1);
    src_sel = 1;
    @(negedge clk) tick_slow = 1;
    @(negedge clk) tick_slow = 0;
    chk(count_o == 1, "R8 unselected slow tick ignored", count_o, 1);

    // R9 R12 halt and compare write while halted
    setup(1, 1, 6);
    step(); step();
    mode_i = 0;
    step(); step(); step();
    chk(count_o == 2, "R9 halt freezes", count_o, 2);
    @(negedge clk) cmp_wr_i = 1; cmp_wdata_i = 3;
    @(negedge clk) cmp_wr_i = 0;
    chk(count_o == 2, "R9 halt keeps count", count_o, 2);
    mode_i = 1;
    step();
    chk(count_o == 3 && cmp_flag_o, "R12 new compare used", count_o, 3);
    step();
    chk(count_o == 0, "R12 wrap at new compare", count_o, 0);

    // R11 flag clear and set-wins
    step(); step();
    clr_flags();
    chk(!cmp_flag_o && !zero_flag_o, "R11 flags cleared", {cmp_flag_o, zero_flag_o}, 0);
    @(negedge clk) tick_fast = 1; flag_clr_i = 2'b01;
    @(negedge clk) tick_fast = 0; flag_clr_i = 2'b00;
    chk(cmp_flag_o, "R11 set wins over clear", cmp_flag_o, 1);
    @(negedge clk) flag_clr_i = 2'b01;
    @(negedge clk) flag_clr_i = 2'b00;
    chk(!cmp_flag_o, "R11 compare flag cleared", cmp_flag_o, 0);

    // R7 set / clear / force output modes
    setup(1, 2, 2);
    step(); step();
    chk(wave_o, "R7 set mode", wave_o, 1);
    step();
    chk(wave_o, "R7 set mode holds", wave_o, 1);
    out_mode_i = 3;
    step(); step();
    chk(!wave_o, "R7 clear mode", wave_o, 0);
    out_mode_i = 0; force_lvl_i = 1;
    @(negedge clk);
    chk(wave_o, "R7 force high", wave_o, 1);
    force_lvl_i = 0;
    @(negedge clk);
    chk(!wave_o, "R7 force low", wave_o, 0);

    // R10 synchronous clear mid-descent
    setup(3, 1, 4);
    for (int k = 0; k < 6; k++) step();
    chk(count_o == 2 && dir_down_o && wave_o, "R3 descent before clear", count_o, 2);
    @(negedge clk) sync_clr_i = 1; tick_fast = 1;
    @(negedge clk) sync_clr_i = 0; tick_fast = 0;
    chk(count_o == 0 && !dir_down_o && !wave_o, "R10 sync clear", count_o, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule